// File: doc/BRIEF.md
# Core-Matrix Operand Address Walker

This block turns a packed 64-bit shared-memory matrix descriptor into the stream of byte addresses needed to read one K-slice of a multiply-accumulate operand tile. The tile is kept in memory as 8x8 core matrices of 16-bit elements, so each core-matrix row is 16 bytes. One K-slice is 16 elements wide, or two 16-byte core-matrix columns. The walker issues one read request per 16-byte row, for a total of 2*MN requests per slice.

A single-cycle start pulse captures the descriptor. The walker checks it, unpacks the base address and the two offsets from their 16-byte-unit fields, and then issues requests over a valid/ready handshake. The row index runs fastest, then the column, and the 8-row group runs slowest. A done pulse follows the final accepted request. A descriptor that selects the 128-byte swizzled layout changes the column step and the row pitch, and it scrambles the offset with an XOR. A malformed descriptor is refused with an error pulse.

Top module: `mat_walker`

## Requirements
- R1: On an accepted start, the descriptor is unpacked as follows. The base address is taken from bits [13:0], the column (leading) offset from bits [29:16] and the group (stride) offset from bits [45:32]. Each field is in 16-byte units, so its byte value is the field times 16.
- R2: With layout type 0, request n carries address base + g*stride + c*lead + r*16, truncated to ADDR_W bits. Here r = n mod 8, c = (n/8) mod 2 and g = n/16. Exactly 2*MN requests are issued per walk.
- R3: The first request is valid in the cycle after the start pulse is accepted. The walk advances by one request on each cycle where valid and ready are both high. While ready is low, valid stays high and the address holds steady.
- R4: done_o is high for exactly one cycle, in the cycle after the final request is accepted. req_valid_o is low in that cycle.
- R5: With layout type 1 (bits [63:61] = 1, 128-byte swizzle), the column step is fixed at 16 bytes and the leading-offset field is ignored. The row pitch is 128 bytes. Each tile offset o is replaced by o XOR ((((o>>4) XOR (o>>8)) & 7) << 4) before the base address is added.
- R6: A descriptor is refused if its version field (bits [47:46]) is not 1, or if its layout type is any value other than 0 or 1. A refused descriptor causes a one-cycle err_o pulse in the cycle after start. It produces no request and no done.
- R7: A start pulse that arrives while a walk is in progress is ignored. The running walk keeps its addresses and its request count.
- R8: The following bits have no effect on any address: the base-offset field (bits [51:49]), the leading-offset unit bit (bit 52), and the unused bits [15:14], [31:30], [48] and [60:53].
- R9: While reset is asserted and right after it is released, req_valid_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that captures desc_i |
| desc_i | input | 64 | Packed shared-memory matrix descriptor |
| req_ready_i | input | 1 | Consumer accepts the current request |
| req_valid_o | output | 1 | A read request is presented |
| req_addr_o | output | ADDR_W | Byte address of the 16-byte row requested |
| done_o | output | 1 | One-cycle pulse after the last request is accepted |
| err_o | output | 1 | One-cycle pulse for a refused descriptor |

## Verification
The walk is exercised with four descriptors:
- The canonical unswizzled one (lead = MN, stride = 8). It separates the column step from the group step.
- An unswizzled one with odd offsets, a maximal base and every ignored bit set. A swapped field, a wrong scale or a leak of the unused bits shows up in the addresses.
- A swizzled one carrying a junk leading field. Only the XOR and the fixed 16/128-byte steps can produce its addresses.
- One that is restarted mid-walk with a different descriptor.

Ready is held high for some walks and throttled with two periodic patterns for others, so that holds and back-to-back accepts both occur. Five malformed descriptors cover bad versions and the reserved layout codes.

// File: rtl/mat_walker_pkg.sv
package mat_walker_pkg;
  localparam int FIELD_W = 14;
  localparam int BYTE_W  = FIELD_W + 4;

  typedef struct packed {
    logic [BYTE_W-1:0] base_b;
    logic [BYTE_W-1:0] lead_b;
    logic [BYTE_W-1:0] stride_b;
    logic              swz;
    logic              bad;
  } desc_fields_t;

  // field in 16-byte units -> byte value
  function automatic logic [BYTE_W-1:0] to_bytes(logic [FIELD_W-1:0] f);
    return {f, 4'b0000};
  endfunction

  function automatic desc_fields_t unpack_desc(logic [63:0] d);
    desc_fields_t o;
    o.base_b   = to_bytes(d[13:0]);
    o.lead_b   = to_bytes(d[29:16]);
    o.stride_b = to_bytes(d[45:32]);
    o.swz      = (d[63:61] == 3'd1);
    o.bad      = (d[47:46] != 2'b01) || (d[63:61] > 3'd1);
    return o;
  endfunction

  // 128-byte swizzle: bits [6:4] xor bits [10:8]
  function automatic logic [31:0] swizzle128(logic [31:0] off);
    return off ^ {25'd0, off[6:4] ^ off[10:8], 4'b0000};
  endfunction
endpackage

// File: rtl/mw_decode.sv
module mw_decode
  import mat_walker_pkg::*;
(
  input  logic [63:0]  desc_i,
  output desc_fields_t fields_o
);
  always_comb fields_o = unpack_desc(desc_i);
endmodule

// File: rtl/mw_counter.sv
module mw_counter #(
  parameter int GROUPS = 16,
  parameter int GRP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [2:0]       row_o,
  output logic             col_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             last_o
);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o <= '0;
      col_o <= 1'b0;
      grp_o <= '0;
    end else if (clear_i) begin
      row_o <= '0;
      col_o <= 1'b0;
      grp_o <= '0;
    end else if (step_i) begin
      row_o <= row_o + 3'd1;
      if (row_o == 3'd7) begin
        col_o <= ~col_o;
        if (col_o) grp_o <= grp_o + 1'b1;
      end
    end
  end

  assign last_o = (row_o == 3'd7) && col_o && (grp_o == GRP_LAST);
endmodule

// File: rtl/mw_addr.sv
module mw_addr
  import mat_walker_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GRP_W  = 4
) (
  input  logic [BYTE_W-1:0] base_b_i,
  input  logic [BYTE_W-1:0] lead_b_i,
  input  logic [BYTE_W-1:0] stride_b_i,
  input  logic              swz_i,
  input  logic [2:0]        row_i,
  input  logic              col_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] grp_x, stride_x, lead_x, pitch_x, row_x, col_x;
  logic [ADDR_W-1:0] off_raw, off_fin;

  always_comb begin
    grp_x    = ADDR_W'(grp_i);
    stride_x = ADDR_W'(stride_b_i);
    lead_x   = swz_i ? ADDR_W'(16) : ADDR_W'(lead_b_i);
    pitch_x  = swz_i ? ADDR_W'(128) : ADDR_W'(16);
    row_x    = ADDR_W'(row_i);
    col_x    = ADDR_W'(col_i);
    off_raw  = grp_x * stride_x + col_x * lead_x + row_x * pitch_x;
    off_fin  = swz_i ? ADDR_W'(swizzle128(32'(off_raw))) : off_raw;
    addr_o   = ADDR_W'(base_b_i) + off_fin;
  end
endmodule

// File: rtl/mat_walker.sv
module mat_walker
  import mat_walker_pkg::*;
#(
  parameter int MN     = 128,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [63:0]       desc_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int GROUPS = MN / 8;
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  desc_fields_t      dec_w;
  desc_fields_t      cur_q;
  logic              busy_q;
  logic [2:0]        row_w;
  logic              col_w;
  logic [GRP_W-1:0]  grp_w;
  logic              last_w;
  logic              accept_w;
  logic              launch_w;
  logic              refuse_w;

  assign accept_w = busy_q && req_ready_i;
  assign launch_w = !busy_q && start_i && !dec_w.bad;
  assign refuse_w = !busy_q && start_i && dec_w.bad;

  mw_decode u_dec (.desc_i(desc_i), .fields_o(dec_w));

  mw_counter #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(launch_w), .step_i(accept_w),
    .row_o(row_w), .col_o(col_w), .grp_o(grp_w), .last_o(last_w)
  );

  mw_addr #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_addr (
    .base_b_i(cur_q.base_b), .lead_b_i(cur_q.lead_b),
    .stride_b_i(cur_q.stride_b), .swz_i(cur_q.swz),
    .row_i(row_w), .col_i(col_w), .grp_i(grp_w), .addr_o(req_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      cur_q  <= '0;
    end else begin
      done_o <= accept_w && last_w;
      err_o  <= refuse_w;
      if (launch_w) begin
        busy_q <= 1'b1;
        cur_q  <= dec_w;
      end else if (accept_w && last_w) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign req_valid_o = busy_q;
endmodule

// File: rtl/mat_walker_chk.sv
module mat_walker_chk #(
  parameter int MN     = 128,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              req_ready_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              done_o,
  input logic              err_o,
  input logic              accept_w,
  input logic              last_w
);
  localparam int REQS  = 2 * MN;
  localparam int CNT_W = $clog2(REQS + 1);

  logic [CNT_W-1:0] acc_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_cnt <= '0;
    else if (done_o) acc_cnt <= '0;
    else if (req_valid_o && req_ready_i) acc_cnt <= acc_cnt + 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));
  assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> $past(start_i));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);
  assert_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && last_w |=> done_o);
  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> acc_cnt == CNT_W'(REQS));
  assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_valid_o && !done_o);
endmodule

bind mat_walker mat_walker_chk #(.MN(MN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_ready_i(req_ready_i),
  .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .done_o(done_o),
  .err_o(err_o), .accept_w(accept_w), .last_w(last_w)
);

// File: tb/sim_mat_walker.sv
module sim_mat_walker;
  localparam int PERIOD = 10;
  localparam int MN     = 128;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [63:0]       desc_i = '0;
  logic              rdy = 1'b1;
  logic              req_valid_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic              done_o, err_o;

  mat_walker #(.MN(MN), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_i(desc_i),
    .req_ready_i(rdy), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #(PERIOD/2) clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string tag = "R9";
  int    rdy_mode = 0;
  int    cyc = 0;
  int    acc = 0;

  // behavioural reference
  int q[$];
  bit m_done = 0, m_err = 0;

  task automatic fill(input logic [63:0] d);
    int base, lead, stride, pitch, off;
    base   = int'(d[13:0]) * 16;
    lead   = int'(d[29:16]) * 16;
    stride = int'(d[45:32]) * 16;
    pitch  = 16;
    if (d[63:61] == 3'd1) begin lead = 16; pitch = 128; end
    for (int g = 0; g < MN / 8; g++)
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < 8; r++) begin
          off = g * stride + c * lead + r * pitch;
          if (d[63:61] == 3'd1)
            off = off ^ ((((off >> 4) ^ (off >> 8)) & 7) << 4);
          q.push_back((base + off) & ((1 << ADDR_W) - 1));
        end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_done = 0; m_err = 0;
    end else begin
      bit nd, ne;
      nd = 0; ne = 0;
      if (q.size() > 0) begin
        if (rdy) begin
          void'(q.pop_front());
          if (q.size() == 0) nd = 1;
        end
      end else if (start_i) begin
        if (desc_i[47:46] != 2'b01 || desc_i[63:61] > 3'd1) ne = 1;
        else fill(desc_i);
      end
      m_done = nd; m_err = ne;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, then set ready for the next edge
  always @(negedge clk) begin
    bit nr;
    cyc++;
    if (rst_n) begin
      chk(tag, longint'(req_valid_o), longint'(q.size() > 0), "valid");
      if (q.size() > 0 && req_valid_o) chk(tag, longint'(req_addr_o), longint'(q[0]), "addr");
      chk("R4", longint'(done_o), longint'(m_done), "done");
      chk("R6", longint'(err_o), longint'(m_err), "err");
      if (done_o) begin
        chk("R2", longint'(acc), longint'(2 * MN), "request count");
        acc = 0;
      end
    end
    case (rdy_mode)
      1:       nr = (cyc % 3) != 0;
      2:       nr = ((cyc * 7) % 5) < 2;
      default: nr = 1'b1;
    endcase
    rdy <= nr;
    if (rst_n && req_valid_o && nr) acc++;
  end

  function automatic logic [63:0] mk(input int base, input int lead, input int stride,
                                     input int ver, input int lay);
    logic [63:0] d;
    d = '0;
    d[13:0]  = 14'(base);
    d[29:16] = 14'(lead);
    d[45:32] = 14'(stride);
    d[47:46] = 2'(ver);
    d[63:61] = 3'(lay);
    return d;
  endfunction

  task automatic pulse(input logic [63:0] d);
    @(negedge clk);
    start_i = 1'b1; desc_i = d;
    @(negedge clk);
    start_i = 1'b0; desc_i = '0;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    chk("R9", longint'({req_valid_o, done_o, err_o}), 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", longint'({req_valid_o, done_o, err_o}), 0, "outputs after reset");

    // R1/R2: canonical unswizzled descriptor, ready always high
    tag = "R1"; rdy_mode = 0;
    pulse(mk(16'h100, MN, 8, 1, 0)); settle();

    // R3: same walk with throttled ready
    tag = "R3"; rdy_mode = 1;
    pulse(mk(16'h100, MN, 8, 1, 0)); settle();
    rdy_mode = 2;
    pulse(mk(16'h2A0, 40, 24, 1, 0)); settle();

    // R8: odd offsets, max base, all ignored bits set
    tag = "R8"; rdy_mode = 0;
    d = mk(16'h3FFF, 5, 300, 1, 0);
    d[51:49] = 3'b111; d[52] = 1'b1; d[15:14] = 2'b11; d[31:30] = 2'b11;
    d[48] = 1'b1; d[60:53] = 8'hFF;
    pulse(d); settle();

    // R5: 128-byte swizzle, junk leading field
    tag = "R5"; rdy_mode = 1;
    d = mk(16'h40, 16'h1234, 64, 1, 1); d[52] = 1'b1;
    pulse(d); settle();

    // R6: refused descriptors
    tag = "R6"; rdy_mode = 0;
    pulse(mk(16'h100, MN, 8, 0, 0)); settle();
    pulse(mk(16'h100, MN, 8, 2, 0)); settle();
    pulse(mk(16'h100, MN, 8, 1, 2)); settle();
    pulse(mk(16'h100, MN, 8, 1, 3)); settle();
    pulse(mk(16'h100, MN, 8, 1, 5)); settle();

    // R7: restart attempt during a walk is ignored
    tag = "R7"; rdy_mode = 2;
    pulse(mk(16'h020, MN, 8, 1, 0));
    repeat (20) @(negedge clk);
    pulse(mk(16'h300, 3, 9, 1, 1));
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule